// File: doc/BRIEF.md
# Panel Row and Column Strobe Generator

This block produces, once per display line, the control strobes that an active-matrix panel's row-scan gate drivers and column source drivers need. A timing generator upstream marks the start of each line with a one-cycle `line_start` pulse. On the first line of a frame it also raises `frame_start` in that same cycle. From that moment a line counter measures every offset in reference-clock cycles. Fixed windows along that counter give the gate shift clock, the vertical start pulse, the gate output blanking, the source latch strobe and the gate-off shaping pulse. A sequencer drives the column polarity, which flips on every line and also changes its starting phase from one frame to the next.

Two override paths sit in front of the gate-side outputs. An already-synchronised all-gates-on request drives the active-low all-on output. While that request is active, the blanking output and the shift clock are held low, so the all-on state wins over blanking. A rate-select input picks the shorter or the longer blanking pulse, to match the two refresh rates the panel supports.

Offsets below count clock edges after the edge that samples `line_start`. The value "at offset n" is the output level during the cycle that follows the n-th edge. Default parameters are used throughout.

Top module: `panel_strobe_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first `line_start`, `gate_clk`, `gate_start`, `gate_oe`, `src_latch`, `gate_shape` and `col_pol` are 0 and `all_on_n` is 1.
- R2: `gate_clk` is 1 at offsets 4 through 23 of every line and 0 at all other offsets, unless R9 holds it low.
- R3: `gate_start` is 1 at offsets 0 through 5, and only on a line whose `line_start` came with `frame_start` = 1. It therefore spans the rising edge of `gate_clk`.
- R4: `gate_oe` is 1 starting at offset 2. It lasts 5 cycles when `fast_rate` was 1 in the cycle before, and 6 cycles when `fast_rate` was 0. It is 0 otherwise, unless R9 holds it low.
- R5: `src_latch` is 1 at offsets 30 through 33 of every line, with its rising edge (latch) preceding its falling edge (drive out).
- R6: `col_pol` changes only at offset 26. That is 4 cycles before `src_latch` rises and well outside the window in which `src_latch` is high or has just fallen.
- R7: `col_pol` inverts on each later line of a frame. On the first line of each frame it takes the frame phase instead. The frame phase toggles on every `frame_start`, starts at 0 after reset, and so makes the first line of the first frame 1.
- R8: `gate_shape` is 1 at offsets 24 through 26 of every line, right after `gate_clk` falls, and never overlaps `gate_clk`.
- R9: `all_on_n` equals the inverse of `all_on_req` from one clock earlier. While `all_on_n` is 0, `gate_oe` and `gate_clk` are 0 whatever the line offset.
- R10: The line counter saturates at offset 255, so no strobe repeats unless a new `line_start` arrives.
- R11: A `line_start` in the middle of a line restarts all offsets from 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| frame_start | input | 1 | High together with `line_start` on the first line of a frame |
| all_on_req | input | 1 | Synchronised request to drive every gate row on |
| fast_rate | input | 1 | 1 selects the short blanking pulse, 0 the long one |
| gate_clk | output | 1 | Gate driver shift clock |
| gate_start | output | 1 | Gate driver vertical start pulse |
| gate_oe | output | 1 | Gate output blanking (1 forces gate outputs low) |
| all_on_n | output | 1 | Active-low all-gates-on override |
| src_latch | output | 1 | Source driver latch and output strobe |
| col_pol | output | 1 | Column drive polarity |
| gate_shape | output | 1 | Gate-off shaping pulse |

## Verification
The bench first runs a four-line frame at the fast rate and then a three-line frame at the slow rate. The two frames tell apart the 5- and 6-cycle blanking widths, and they show whether the first-line polarity follows the frame phase rather than simply continuing the line toggle. An all-on request raised across the blanking and shift-clock windows shows that the override masks both and beats blanking. A `line_start` pushed in mid-line separates a true restart of the offsets from a counter that runs on. A long idle stretch with no `line_start` shows that the counter saturates and that no strobe repeats.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  // Decoded per-line strobe set before override masking
  typedef struct packed {
    logic ckv;
    logic stv;
    logic oe;
    logic stb;
    logic gv;
  } gate_strobe_t;

endpackage

// File: rtl/strobe_line_timer.sv
module strobe_line_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          frame_start,
  output logic          run,
  output logic [CW-1:0] cnt,
  output logic          frame_line,
  output logic          frame_phase
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          run_d;
  logic [CW-1:0] cnt_d;
  logic          fl_d;
  logic          ph_d;

  always_comb begin
    run_d = run;
    cnt_d = cnt;
    fl_d  = frame_line;
    ph_d  = frame_phase;
    if (line_start) begin
      run_d = 1'b1;
      cnt_d = '0;
      fl_d  = frame_start;
      if (frame_start) ph_d = ~frame_phase;
    end else if (run && (cnt != CNT_MAX)) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run         <= 1'b0;
      cnt         <= '0;
      frame_line  <= 1'b0;
      frame_phase <= 1'b0;
    end else begin
      run         <= run_d;
      cnt         <= cnt_d;
      frame_line  <= fl_d;
      frame_phase <= ph_d;
    end
  end

endmodule

// File: rtl/strobe_window.sv
module strobe_window #(
  parameter int CW    = 8,
  parameter int START = 0,
  parameter int LEN   = 1
) (
  input  logic          en,
  input  logic [CW-1:0] cnt,
  output logic          active
);

  localparam int          STOP_I = START + LEN;
  localparam logic [CW:0] LO     = START[CW:0];
  localparam logic [CW:0] HI     = STOP_I[CW:0];

  logic [CW:0] cnt_x;

  assign cnt_x  = {1'b0, cnt};
  assign active = en && (cnt_x >= LO) && (cnt_x < HI);

endmodule

// File: rtl/strobe_polarity.sv
module strobe_polarity #(
  parameter int CW  = 8,
  parameter int TOG = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  logic          frame_line,
  input  logic          frame_phase,
  output logic          pol
);

  localparam logic [CW-1:0] TOG_AT = TOG[CW-1:0];

  logic pol_d;
  logic pol_en;

  assign pol_en = run && (cnt == TOG_AT);

  always_comb begin
    pol_d = pol;
    if (pol_en) pol_d = frame_line ? frame_phase : ~pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol <= 1'b0;
    else        pol <= pol_d;
  end

endmodule

// File: rtl/panel_strobe_gen.sv
module panel_strobe_gen #(
  parameter int CW          = 8,
  parameter int CKV_RISE    = 4,
  parameter int CKV_HIGH    = 20,
  parameter int STV_HOLD    = 2,
  parameter int OE_START    = 2,
  parameter int OE_LEN_FAST = 5,
  parameter int OE_LEN_SLOW = 6,
  parameter int STB_START   = 30,
  parameter int STB_LEN     = 4,
  parameter int POL_SETUP   = 4,
  parameter int GV_DELAY    = 0,
  parameter int GV_LEN      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic frame_start,
  input  logic all_on_req,
  input  logic fast_rate,
  output logic gate_clk,
  output logic gate_start,
  output logic gate_oe,
  output logic all_on_n,
  output logic src_latch,
  output logic col_pol,
  output logic gate_shape
);
  import strobe_pkg::*;

  localparam int STV_LEN  = CKV_RISE + STV_HOLD;
  localparam int GV_START = CKV_RISE + CKV_HIGH + GV_DELAY;
  localparam int POL_TOG  = STB_START - POL_SETUP - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  logic          run, frame_line, frame_phase;
  logic [CW-1:0] cnt;

  strobe_line_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n_i), .line_start(line_start),
    .frame_start(frame_start), .run(run), .cnt(cnt),
    .frame_line(frame_line), .frame_phase(frame_phase)
  );

  gate_strobe_t dec;
  logic         oe_fast, oe_slow;

  strobe_window #(.CW(CW), .START(CKV_RISE), .LEN(CKV_HIGH)) ckv_w (
    .en(run), .cnt(cnt), .active(dec.ckv));
  strobe_window #(.CW(CW), .START(0), .LEN(STV_LEN)) stv_w (
    .en(run && frame_line), .cnt(cnt), .active(dec.stv));
  strobe_window #(.CW(CW), .START(STB_START), .LEN(STB_LEN)) stb_w (
    .en(run), .cnt(cnt), .active(dec.stb));
  strobe_window #(.CW(CW), .START(GV_START), .LEN(GV_LEN)) gv_w (
    .en(run), .cnt(cnt), .active(dec.gv));

  // one window per supported refresh rate
  generate
    if (OE_LEN_FAST == OE_LEN_SLOW) begin : g_oe_one
      strobe_window #(.CW(CW), .START(OE_START), .LEN(OE_LEN_FAST)) oe_w (
        .en(run), .cnt(cnt), .active(oe_fast));
      assign oe_slow = oe_fast;
    end else begin : g_oe_two
      strobe_window #(.CW(CW), .START(OE_START), .LEN(OE_LEN_FAST)) oe_f (
        .en(run), .cnt(cnt), .active(oe_fast));
      strobe_window #(.CW(CW), .START(OE_START), .LEN(OE_LEN_SLOW)) oe_s (
        .en(run), .cnt(cnt), .active(oe_slow));
    end
  endgenerate

  logic rate_q, rate_d;
  logic allon_n_q, allon_n_d;

  assign rate_d    = fast_rate;
  assign allon_n_d = ~all_on_req;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rate_q    <= 1'b0;
      allon_n_q <= 1'b1;
    end else begin
      rate_q    <= rate_d;
      allon_n_q <= allon_n_d;
    end
  end

  assign dec.oe = rate_q ? oe_fast : oe_slow;

  strobe_polarity #(.CW(CW), .TOG(POL_TOG)) pol_i (
    .clk(clk), .rst_n(rst_n_i), .run(run), .cnt(cnt),
    .frame_line(frame_line), .frame_phase(frame_phase), .pol(col_pol));

  // all-on override outranks blanking and parks the shift clock
  assign gate_clk   = dec.ckv & allon_n_q;
  assign gate_oe    = dec.oe  & allon_n_q;
  assign gate_start = dec.stv;
  assign src_latch  = dec.stb;
  assign gate_shape = dec.gv;
  assign all_on_n   = allon_n_q;

endmodule

// File: rtl/panel_strobe_chk.sv
module panel_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic gate_clk,
  input logic gate_oe,
  input logic all_on_n,
  input logic src_latch,
  input logic col_pol,
  input logic gate_shape
);

  // R9
  allon_masks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_on_n |-> (!gate_oe && !gate_clk));

  // R6
  pol_clear_of_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(col_pol) |-> (!src_latch && !$past(src_latch)));

  // R8
  shape_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_shape |-> !gate_clk);

  // R4
  blank_apart_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_oe |-> !src_latch);

  // R5
  latch_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_latch) |-> (!gate_clk && !gate_shape));

endmodule

bind panel_strobe_gen panel_strobe_chk chk_i (
  .clk(clk), .rst_n(rst_n), .gate_clk(gate_clk), .gate_oe(gate_oe),
  .all_on_n(all_on_n), .src_latch(src_latch), .col_pol(col_pol),
  .gate_shape(gate_shape)
);

// File: tb/panel_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module panel_strobe_gen_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0, frame_start = 1'b0, all_on_req = 1'b0, fast_rate = 1'b0;
  logic gate_clk, gate_start, gate_oe, all_on_n, src_latch, col_pol, gate_shape;

  always #5 clk = ~clk;

  panel_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
    .all_on_req(all_on_req), .fast_rate(fast_rate), .gate_clk(gate_clk),
    .gate_start(gate_start), .gate_oe(gate_oe), .all_on_n(all_on_n),
    .src_latch(src_latch), .col_pol(col_pol), .gate_shape(gate_shape));

  int tests = 0, fails = 0;
  bit checking = 0;
  string seg = "R1";

  task automatic chk(input bit ok, input string req, input string nm,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("[TB] FAIL %s %s (%s) actual=%0d expected=%0d @%0t",
               req, nm, seg, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0;
  bit m_run = 0, m_fl = 0, m_phase = 0, m_pol = 0, m_allon = 0, m_fast = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_fl = 0; m_phase = 0;
      m_pol = 0; m_allon = 0; m_fast = 0;
    end else begin
      if (m_run && m_cnt == 26 - 1) m_pol = m_fl ? m_phase : !m_pol;
      m_allon = all_on_req;
      m_fast  = fast_rate;
      if (line_start) begin
        m_cnt = 0; m_run = 1; m_fl = frame_start;
        if (frame_start) m_phase = !m_phase;
      end else if (m_run && m_cnt < 255) m_cnt++;
    end
  end

  function automatic bit inw(int c, int lo, int len);
    return (c >= lo) && (c < lo + len);
  endfunction

  bit prev_pol = 0;

  always @(negedge clk) begin
    if (checking) begin
      bit e_ckv, e_stv, e_oe, e_stb, e_gv;
      e_ckv = m_run && inw(m_cnt, 4, 20) && !m_allon;
      e_stv = m_run && m_fl && inw(m_cnt, 0, 6);
      e_oe  = m_run && inw(m_cnt, 2, m_fast ? 5 : 6) && !m_allon;
      e_stb = m_run && inw(m_cnt, 30, 4);
      e_gv  = m_run && inw(m_cnt, 24, 3);
      chk(gate_clk === e_ckv, m_allon ? "R9" : "R2", "gate_clk", gate_clk, e_ckv);
      chk(gate_start === e_stv, "R3", "gate_start", gate_start, e_stv);
      chk(gate_oe === e_oe, m_allon ? "R9" : "R4", "gate_oe", gate_oe, e_oe);
      chk(src_latch === e_stb, "R5", "src_latch", src_latch, e_stb);
      chk(gate_shape === e_gv, "R8", "gate_shape", gate_shape, e_gv);
      chk(all_on_n === !m_allon, "R9", "all_on_n", all_on_n, !m_allon);
      chk(col_pol === m_pol, "R7", "col_pol", col_pol, m_pol);
      if (col_pol !== prev_pol)
        chk(m_cnt == 26, "R6", "col_pol change offset", m_cnt, 26);
    end
    prev_pol = col_pol;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_line(input bit fs, input int len);
    @(negedge clk);
    line_start = 1; frame_start = fs;
    @(negedge clk);
    line_start = 0; frame_start = 0;
    idle(len - 2);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    seg = "R1";
    chk(gate_clk === 0 && gate_start === 0 && gate_oe === 0, "R1", "gate outputs", gate_clk, 0);
    chk(src_latch === 0 && gate_shape === 0 && col_pol === 0, "R1", "source outputs", src_latch, 0);
    chk(all_on_n === 1, "R1", "all_on_n", all_on_n, 1);
    rst_n = 1;
    checking = 1;
    seg = "R1 after release";
    idle(8);
    // fast-rate frame, 4 lines
    seg = "fast frame R4 R7"; fast_rate = 1;
    run_line(1, 48); run_line(0, 48); run_line(0, 48); run_line(0, 48);
    // slow-rate frame, 3 lines
    seg = "slow frame R4 R7"; fast_rate = 0;
    run_line(1, 48); run_line(0, 48); run_line(0, 48);
    // all-on override across blanking and shift clock
    seg = "override R9";
    run_line(1, 48);
    @(negedge clk); line_start = 1;
    @(negedge clk); line_start = 0;
    all_on_req = 1; idle(10); all_on_req = 0; idle(36);
    // mid-line restart
    seg = "restart R11";
    @(negedge clk); line_start = 1;
    @(negedge clk); line_start = 0; idle(15);
    run_line(0, 48);
    // saturation: no strobe repeats
    seg = "saturate R10";
    idle(300);
    seg = "resume R2";
    run_line(1, 48); run_line(0, 48);
    checking = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule